// File: doc/BRIEF.md
# Serial Frame Bus Arbiter

This block wins and holds a shared control and signalling channel for one device on a time-division serial bus. The bus is wired-AND: a device that drives a 0 pulls the line low, and a device that drives a 1 lets it go. Each frame carries a status octet. Its bit 3 reports whether the channel is taken (1 = free, 0 = taken), and its bits 2..0 carry the 3-bit address of whoever holds the channel or is contending for it.

The device asks for the channel when a software enable is set or when its local link controller has a frame waiting. If bit 3 reads free in a frame, the block sends its own address in the same octet, most significant bit first, and reads each bit back. A released bit that reads back as 0 means a lower address is also on the bus, so the block stops driving for the rest of that frame. If it sends the whole address without a loss, the block takes the grant at the next frame. It then drives bit 3 low until the request goes away. After it gives the channel up, it may not contend again until bit 3 has read free in two frames in a row.

The surrounding logic supplies a frame strobe and one bit-slot strobe per octet bit. It also feeds the bus level back on `bus_in`.

Top module: `tdm_frame_arbiter`

## Requirements
- R1: The request is `sw_req` OR `tx_pending`. When neither is set and the device neither holds the grant nor is contending, `bus_out` is 1 in every slot.
- R2: In octet bits 7 to 4, `bus_out` is always 1.
- R3: The octet goes out most significant bit first. `frame_strobe` points the slot index at bit 7, and each following `slot_strobe` moves it down by one. `bus_in` is sampled on the same cycle as the `slot_strobe` of that bit.
- R4: A requesting device with no holdoff pending starts contention only when bit 3 reads 1 in that frame. It then drives `my_addr` on bits 2..0 of the same octet.
- R5: During contention, if the device drives a 1 and reads back 0, it has lost. It drives 1 on the remaining address bits of that frame and gets no grant from that frame.
- R6: When several devices contend in one frame, the device with the numerically lowest address is the one that gets the grant.
- R7: After a whole address is sent without a loss, `grant` rises on the next `frame_strobe`, provided the request is still present there.
- R8: While `grant` is high, the device drives 0 on bit 3 and `my_addr` on bits 2..0 in every frame.
- R9: When the request is absent at a `frame_strobe` while the device holds the grant, `grant` falls and bit 3 is driven 1 from that frame on.
- R10: A holdoff starts when the device gives up an access, or when it wins while the request has already gone. The device may not contend until bit 3 has read 1 in two consecutive frames. A 0 on bit 3 restarts the count, and contention becomes possible from the frame after the second free one.
- R11: A device with address 7 that contends alone on a free bus drives 1 on all address bits and still gets the grant.
- R12: A synchronous reset clears the grant, ends any contention and clears the holdoff, so the first free frame after reset can be contended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | One-cycle pulse at the start of each frame |
| slot_strobe | input | 1 | One-cycle pulse per octet bit slot |
| bus_in | input | 1 | Wired-AND bus level read back for the current slot |
| sw_req | input | 1 | Software channel request |
| tx_pending | input | 1 | Local link controller has a frame waiting |
| my_addr | input | 3 | Programmed arbitration address of this device |
| bus_out | output | 1 | Bit driven in the current slot (1 = released) |
| grant | output | 1 | Device holds the channel |

## Verification
The bench builds the block with its default sizes: an 8-bit octet, a 3-bit address and a holdoff of two frames. With these sizes every address value and every loss position (bit 2, 1 or 0) can be reached in a few frames. The holdoff restart can be forced with a single busy frame. A reactive rival device on the bench contends, loses and releases the line bit by bit, so lowest-address-wins is exercised against real read-back. Random frames mix requests, rival addresses, busy owners and line noise. Directed frames cover reset in the middle of an access and address 7.

// File: rtl/tdm_arb_pkg.sv
`timescale 1ns/1ps
package tdm_arb_pkg;

    localparam int ARB_OCT_W       = 8;
    localparam int ARB_ADDR_W      = 3;
    localparam int ARB_HOLD_FRAMES = 2;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_CONTEND = 2'd1,
        ARB_WON     = 2'd2,
        ARB_OWN     = 2'd3
    } arb_st_e;

    // True in states where the device puts its address on the bus
    function automatic logic arb_drives_addr(input arb_st_e st);
        return (st == ARB_CONTEND) || (st == ARB_OWN);
    endfunction

endpackage

// File: rtl/tdm_arb_slot_ctr.sv
`timescale 1ns/1ps
module tdm_arb_slot_ctr #(
    parameter int OCT_W  = 8,
    parameter int SLOT_W = $clog2(OCT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strobe,
    input  logic              slot_strobe,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_tick
);
    localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(OCT_W - 1);

    // A frame strobe wins over a coincident slot strobe
    assign slot_tick = slot_strobe && !frame_strobe;

    always_ff @(posedge clk) begin
        if (rst || frame_strobe) begin
            slot_idx <= TOP_SLOT;
        end else if (slot_tick) begin
            slot_idx <= slot_idx - 1'b1;
        end
    end
endmodule

// File: rtl/tdm_arb_holdoff.sv
`timescale 1ns/1ps
module tdm_arb_holdoff #(
    parameter int HOLD_FRAMES = 2,
    parameter int CNT_W       = $clog2(HOLD_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic acc_tick,
    input  logic line,
    output logic clear
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_FRAMES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= RELOAD;
        end else if (acc_tick && cnt != '0) begin
            // free frame counts down, a busy frame restarts the run
            cnt <= line ? cnt - 1'b1 : RELOAD;
        end
    end

    assign clear = (cnt == '0);
endmodule

// File: rtl/tdm_arb_fsm.sv
`timescale 1ns/1ps
module tdm_arb_fsm
    import tdm_arb_pkg::*;
#(
    parameter int OCT_W   = 8,
    parameter int ADDR_W  = 3,
    parameter int SLOT_W  = $clog2(OCT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strobe,
    input  logic              slot_tick,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              line,
    input  logic              req,
    input  logic              hold_clear,
    input  logic [OCT_W-1:0]  addr_ext,
    output arb_st_e           state,
    output logic              hold_start
);
    localparam logic [SLOT_W-1:0] ACC_SLOT = SLOT_W'(ADDR_W);

    logic lost_now;

    assign lost_now   = addr_ext[slot_idx] && !line;
    assign hold_start = frame_strobe && !req &&
                        (state == ARB_WON || state == ARB_OWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
        end else if (frame_strobe) begin
            unique case (state)
                ARB_WON:     state <= req ? ARB_OWN : ARB_IDLE;
                ARB_OWN:     state <= req ? ARB_OWN : ARB_IDLE;
                ARB_CONTEND: state <= ARB_IDLE;
                default:     state <= ARB_IDLE;
            endcase
        end else if (slot_tick) begin
            unique case (state)
                ARB_IDLE: begin
                    if (slot_idx == ACC_SLOT && req && hold_clear && line)
                        state <= ARB_CONTEND;
                end
                ARB_CONTEND: begin
                    if (slot_idx < ACC_SLOT) begin
                        if (lost_now)
                            state <= ARB_IDLE;
                        else if (slot_idx == '0)
                            state <= ARB_WON;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/tdm_frame_arbiter.sv
`timescale 1ns/1ps
module tdm_frame_arbiter
    import tdm_arb_pkg::*;
#(
    parameter int OCT_W       = ARB_OCT_W,
    parameter int ADDR_W      = ARB_ADDR_W,
    parameter int HOLD_FRAMES = ARB_HOLD_FRAMES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strobe,
    input  logic              slot_strobe,
    input  logic              bus_in,
    input  logic              sw_req,
    input  logic              tx_pending,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              bus_out,
    output logic              grant
);
    localparam int SLOT_W = $clog2(OCT_W);
    localparam logic [SLOT_W-1:0] ACC_SLOT = SLOT_W'(ADDR_W);

    logic [SLOT_W-1:0] slot_idx;
    logic              slot_tick;
    logic              hold_clear;
    logic              hold_start;
    logic              req;
    logic [OCT_W-1:0]  addr_ext;
    arb_st_e           arb_state;

    assign req      = sw_req || tx_pending;
    assign addr_ext = {{(OCT_W - ADDR_W){1'b1}}, my_addr};

    tdm_arb_slot_ctr #(.OCT_W(OCT_W)) u_slot (
        .clk          (clk),
        .rst          (rst),
        .frame_strobe (frame_strobe),
        .slot_strobe  (slot_strobe),
        .slot_idx     (slot_idx),
        .slot_tick    (slot_tick)
    );

    tdm_arb_holdoff #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .start    (hold_start),
        .acc_tick (slot_tick && slot_idx == ACC_SLOT),
        .line     (bus_in),
        .clear    (hold_clear)
    );

    tdm_arb_fsm #(.OCT_W(OCT_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .frame_strobe (frame_strobe),
        .slot_tick    (slot_tick),
        .slot_idx     (slot_idx),
        .line         (bus_in),
        .req          (req),
        .hold_clear   (hold_clear),
        .addr_ext     (addr_ext),
        .state        (arb_state),
        .hold_start   (hold_start)
    );

    always_comb begin
        if (slot_idx == ACC_SLOT)
            bus_out = (arb_state != ARB_OWN);
        else if (slot_idx > ACC_SLOT)
            bus_out = 1'b1;
        else if (arb_drives_addr(arb_state))
            bus_out = addr_ext[slot_idx];
        else
            bus_out = 1'b1;
    end

    assign grant = (arb_state == ARB_OWN);
endmodule

// File: rtl/tdm_arb_chk.sv
`timescale 1ns/1ps
module tdm_arb_chk
    import tdm_arb_pkg::*;
#(
    parameter int SLOT_W  = 3,
    parameter int ACC_POS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_strobe,
    input logic              sw_req,
    input logic              tx_pending,
    input logic              grant,
    input logic              bus_out,
    input logic [SLOT_W-1:0] slot_idx,
    input arb_st_e           state
);
    localparam logic [SLOT_W-1:0] ACC_SLOT = SLOT_W'(ACC_POS);

    // R7
    grant_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> $past(frame_strobe));

    // R9
    grant_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(grant) |-> $past(!(sw_req || tx_pending)));

    // R2
    high_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_idx > ACC_SLOT) |-> bus_out);

    // R8
    own_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && slot_idx == ACC_SLOT) |-> !bus_out);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant && state != ARB_CONTEND) |-> bus_out);
endmodule

bind tdm_frame_arbiter tdm_arb_chk #(
    .SLOT_W  ($clog2(OCT_W)),
    .ACC_POS (ADDR_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_strobe (frame_strobe),
    .sw_req       (sw_req),
    .tx_pending   (tx_pending),
    .grant        (grant),
    .bus_out      (bus_out),
    .slot_idx     (slot_idx),
    .state        (arb_state)
);

// File: tb/test_tdm_frame_arbiter.sv
`timescale 1ns/1ps
module test_tdm_frame_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_strobe = 1'b0;
    logic       slot_strobe = 1'b0;
    logic       bus_in = 1'b1;
    logic       sw_req = 1'b0;
    logic       tx_pending = 1'b0;
    logic [2:0] my_addr = 3'd5;
    logic       bus_out;
    logic       grant;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model: 0 idle, 1 contend, 2 won, 3 own
    int m_st = 0;
    int m_hold = 0;

    always #2.5 clk = ~clk;

    tdm_frame_arbiter i_tdm_frame_arbiter (
        .clk          (clk),
        .rst          (rst),
        .frame_strobe (frame_strobe),
        .slot_strobe  (slot_strobe),
        .bus_in       (bus_in),
        .sw_req       (sw_req),
        .tx_pending   (tx_pending),
        .my_addr      (my_addr),
        .bus_out      (bus_out),
        .grant        (grant)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_drive(input int i);
        if (i > 3) return 1'b1;
        if (i == 3) return (m_st != 3);
        if (m_st == 3 || m_st == 1) return my_addr[i];
        return 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_strobe = 1'b0;
        slot_strobe = 1'b0;
        bus_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0;
        m_hold = 0;
        #1;
        check("R12 reset grant", {7'd0, grant}, 8'h00);
        check("R12 reset bus_out", {7'd0, bus_out}, 8'h01);
    endtask

    // One frame: frame strobe, then eight slots. The rival device contends
    // with r_addr, reads back, and releases after a loss.
    task automatic run_frame(input bit rq_sw, input bit rq_tx, input bit busy,
                             input bit r_req, input logic [2:0] r_addr,
                             input logic [7:0] noise,
                             input string tg_g, input string tg_o);
        logic [7:0] got;
        logic [7:0] exp;
        bit req;
        bit r_on;
        bit r_lost;
        req = rq_sw || rq_tx;
        sw_req = rq_sw;
        tx_pending = rq_tx;
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        if (m_st == 2) begin
            if (req) m_st = 3;
            else begin m_st = 0; m_hold = 2; end
        end else if (m_st == 3 && !req) begin
            m_st = 0; m_hold = 2;
        end else if (m_st == 1) begin
            m_st = 0;
        end
        #1;
        check(tg_g, {7'd0, grant}, {7'd0, (m_st == 3)});
        r_on = 1'b0;
        r_lost = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic o;
            logic d;
            logic e;
            logic ln;
            logic ml;
            o = noise[i];
            if (i == 3 && busy) o = 1'b0;
            if (i < 3 && r_on && !r_lost) o = o & r_addr[i];
            e = exp_drive(i);
            slot_strobe = 1'b1;
            #1;
            d = bus_out;
            got[i] = d;
            exp[i] = e;
            ln = d & o;
            bus_in = ln;
            ml = e & o;
            if (i == 3 && m_st == 0) begin
                if (m_hold > 0) m_hold = ml ? m_hold - 1 : 2;
                else if (req && ml) m_st = 1;
            end
            if (i < 3 && m_st == 1) begin
                if (my_addr[i] && !ml) m_st = 0;
                else if (i == 0) m_st = 2;
            end
            if (i == 3) r_on = r_req && ln;
            if (i < 3 && r_on && !r_lost && r_addr[i] && !ln) r_lost = 1'b1;
            @(negedge clk);
        end
        slot_strobe = 1'b0;
        bus_in = 1'b1;
        check(tg_o, got, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1, R2: idle device releases every slot
        run_frame(0, 0, 0, 0, 3'd0, 8'hFF, "R1 idle grant", "R1 R2 idle octet");
        if (exp_drive(7) !== 1'b1) n_bad++;

        // R4: contend on free bus, expect F D
        run_frame(1, 0, 0, 0, 3'd0, 8'hFF, "R4 contend grant", "R4 contend octet");
        // R7: grant, R3 and R8: owner octet F5 (MSB first)
        run_frame(1, 0, 0, 0, 3'd0, 8'hFF, "R7 grant rise", "R3 R8 owner octet");
        run_frame(1, 0, 1, 1, 3'd2, 8'hFF, "R8 hold grant", "R8 owner octet busy");
        // R9: withdraw
        run_frame(0, 0, 0, 0, 3'd0, 8'hFF, "R9 grant fall", "R9 release octet");

        // R10: holdoff with a busy frame restarting the count (tx request only)
        run_frame(0, 1, 1, 0, 3'd0, 8'hFF, "R10 busy grant", "R10 busy octet");
        run_frame(0, 1, 0, 0, 3'd0, 8'hFF, "R10 free1 grant", "R10 free1 octet");
        run_frame(0, 1, 0, 0, 3'd0, 8'hFF, "R10 free2 grant", "R10 free2 octet");
        run_frame(0, 1, 0, 0, 3'd0, 8'hFF, "R10 after grant", "R10 contend octet");
        run_frame(0, 1, 0, 0, 3'd0, 8'hFF, "R1 tx grant", "R1 tx owner octet");

        // R12: reset while owning, then contend at once
        do_reset();
        // R5, R6: rival 3 beats us (5), we lose at bit 2
        run_frame(1, 0, 0, 1, 3'd3, 8'hFF, "R5 lose grant", "R5 lose octet");
        run_frame(1, 0, 0, 1, 3'd3, 8'hFF, "R6 lost no grant", "R6 rival low octet");
        // R6: rival 6 loses to us at bit 1
        run_frame(1, 0, 0, 1, 3'd6, 8'hFF, "R6 win grant", "R6 win octet");
        run_frame(1, 0, 0, 0, 3'd0, 8'hFF, "R6 grant high", "R6 owner octet");

        // R11: address 7 alone on a free bus
        do_reset();
        my_addr = 3'd7;
        run_frame(1, 0, 0, 0, 3'd0, 8'hFF, "R11 grant", "R11 contend octet");
        run_frame(1, 0, 0, 0, 3'd0, 8'hFF, "R11 grant rise", "R11 owner octet");

        // random frames
        for (int f = 0; f < 400; f++) begin
            bit s;
            bit t;
            bit b;
            bit rr;
            logic [2:0] ra;
            logic [7:0] nz;
            if (f % 50 == 0) my_addr = 3'($urandom % 8);
            s  = ($urandom % 3) != 0;
            t  = ($urandom % 4) == 0;
            b  = ($urandom % 6) == 0;
            rr = ($urandom % 2) == 0;
            ra = 3'($urandom % 8);
            nz = (($urandom % 8) == 0) ? 8'($urandom) : 8'hFF;
            run_frame(s, t, b, rr, ra, nz, "R7 R9 random grant", "R5 R10 random octet");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule